// File: doc/BRIEF.md
# SPI Port with Mode Fault Detection

This block is a byte-wide SPI port that can act as bus master or as bus slave. Each transfer is full duplex: one byte goes out while one byte comes in, most significant bit first, over eight serial clock cycles. As master, the block makes the serial clock itself by dividing the system clock by a power of two. As slave, it synchronises the external clock, slave-select and data lines into the system clock domain and follows the edges it sees there. Clock polarity and clock phase can each be set either way in both roles.

Slave select has two uses. In slave mode it frames the bytes. With phase 0 each byte begins when select falls, and select must go high between bytes. With phase 1 select may stay low across a run of bytes, and the transmit buffer is reloaded after every sixteenth edge. In master mode, and when fault detection is enabled, select is a collision input: if another master pulls it low, the block raises a sticky mode-fault flag. It then drops all of its pin drivers and abandons the byte in progress. The rest of the chip sees the block through a small set of ports: transmit data with a load strobe, the received byte with a full flag and an acknowledge, and the fault flag with its clear strobe.

Top module: `spi_port`

## Requirements
- R1: In master mode, a `tx_load` pulse while idle sends `tx_data` on `mosi_o` MSB first. It assembles the eight `miso_i` samples MSB first into `rx_data`, and `rx_full` rises two clocks after the eighth sampling edge.
- R2: A master transfer produces exactly 16 serial clock edges, with 2^`div_sel` system clocks between consecutive edges.
- R3: In master mode, `sck_o` rests at the level of `cpol` whenever no transfer is running.
- R4: With `cpha` = 0, data is sampled on odd-numbered edges and the outgoing bit changes on even edges 2 to 14. With `cpha` = 1, data is sampled on even edges and the outgoing bit changes on odd edges 3 to 15. In both cases bit 7 is presented before the first edge.
- R5: Pin enables are registered. With `en` low, all three enables are low. As master, `sck_oe` and `mosi_oe` are high and `miso_oe` is low. As slave, `sck_oe` and `mosi_oe` are low, and `miso_oe` is high only while the synchronised `ss_n_i` is low.
- R6: In slave mode with `cpha` = 0, a fall of `ss_n_i` starts a byte. The last value written through `tx_load` appears on `miso_o` from bit 7 down, and the byte shifted in on `mosi_i` ends up in `rx_data` with `rx_full` set.
- R7: In slave mode with `cpha` = 1 and `ss_n_i` held low, consecutive bytes are exchanged back to back. The transmit buffer is reloaded after each sixteenth edge, so a `tx_load` during a byte supplies the next byte.
- R8: While a slave's `ss_n_i` is high, `miso_oe` is low and serial clock edges are ignored. A byte cut short by select going high is discarded and does not disturb the next frame.
- R9: In master mode with `fault_en` set, a low level on `ss_n_i` sets `mode_fault`. The block then stops driving `sck_o` and `mosi_o`, the transfer is aborted without setting `rx_full`, and the block stays inactive while the flag is set.
- R10: In master mode with `fault_en` clear, `ss_n_i` has no effect, and a transfer completes normally even while it is low.
- R11: `mode_fault` stays set until a `fault_clr` pulse. If a new fault condition arrives in the same cycle as the clear, the set wins.
- R12: In slave mode with `fault_en` set, `ss_n_i` rising after at least one edge of an unfinished byte sets `mode_fault`. With `fault_en` clear, the same event leaves `mode_fault` low.
- R13: `rx_ack` clears `rx_full`. A byte completing in the same cycle as the acknowledge leaves `rx_full` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable |
| master_sel | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase, selects the sampling edge |
| fault_en | input | 1 | Enables mode-fault detection |
| div_sel | input | DIV_W | Master half period is 2^div_sel clocks |
| tx_data | input | DW | Byte to transmit |
| tx_load | input | 1 | Writes tx_data; starts a transfer in master mode |
| rx_data | output | DW | Last byte received |
| rx_full | output | 1 | Received byte available |
| rx_ack | input | 1 | Clears rx_full |
| mode_fault | output | 1 | Sticky mode-fault flag |
| fault_clr | input | 1 | Clears mode_fault |
| busy | output | 1 | Master transfer in progress |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Drive enable for sck_o |
| ss_n_i | input | 1 | Active-low slave select / collision input |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Drive enable for miso_o |
| miso_i | input | 1 | Master data in |

## Verification
A fault in the edge counters or the divider shows up on `sck_o` within one half period, as a wrong edge spacing or a seventeenth edge. A wrong phase or a wrong shift order corrupts both the captured MOSI byte and `rx_data` in the same transfer, because the bench acts as a correctly behaving peer on the other end of the link. A stuck or missing mode fault is caught within a few clocks, because a clock-by-clock monitor requires every pin enable to be low one cycle after the flag is seen. A slave that fails to forget an aborted byte, or fails to reload between bytes, delivers a wrong byte on the very next frame.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  // An edge samples when its oddness differs from the phase bit.
  function automatic logic edge_samples(input logic phase, input logic idx_odd);
    return idx_odd ^ phase;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_mclk.sv
module spi_mclk #(
  parameter int DW    = 8,
  parameter int DIV_W = 3,
  localparam int EW   = $clog2(2*DW+1),
  localparam int CW   = 1 << DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div_sel,
  output logic             sck,
  output logic             edge_stb,
  output logic [EW-1:0]    edge_idx,
  output logic             busy
);

  localparam logic [EW-1:0] LAST_EDGE = EW'(2*DW - 1);

  logic [CW-1:0] div_q;
  logic [CW-1:0] half_m1;
  logic [EW-1:0] edges_q;
  logic          busy_q;
  logic          sck_q;
  logic          wrap;

  assign half_m1  = (CW'(1) << div_sel) - CW'(1);
  assign wrap     = busy_q && (div_q == half_m1);
  assign edge_stb = wrap;
  assign edge_idx = edges_q + EW'(1);
  assign sck      = sck_q;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      div_q   <= '0;
      edges_q <= '0;
      sck_q   <= 1'b0;
    end else if (abort) begin
      busy_q  <= 1'b0;
      div_q   <= '0;
      edges_q <= '0;
      sck_q   <= cpol;
    end else if (!busy_q) begin
      sck_q   <= cpol;
      div_q   <= '0;
      edges_q <= '0;
      if (start) busy_q <= 1'b1;
    end else if (wrap) begin
      div_q   <= '0;
      sck_q   <= ~sck_q;
      edges_q <= edges_q + EW'(1);
      if (edges_q == LAST_EDGE) busy_q <= 1'b0;
    end else begin
      div_q <= div_q + CW'(1);
    end
  end

  p_edge_bound_r2: assert property (@(posedge clk) disable iff (rst)
    edges_q <= EW'(2*DW));

  p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> (sck_q == $past(cpol)));

endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DW = 8,
  localparam int EW = $clog2(2*DW+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          edge_stb,
  input  logic [EW-1:0] edge_idx,
  input  logic          cpha,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          done,
  output logic [DW-1:0] word
);

  import spi_port_pkg::*;

  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] word_q;
  logic          done_q;
  logic          is_sample;
  logic          do_sample;
  logic          do_shift;
  logic          last_sample;

  assign is_sample   = edge_samples(cpha, edge_idx[0]);
  assign do_sample   = edge_stb && is_sample;
  assign do_shift    = edge_stb && !is_sample &&
                       (cpha ? (edge_idx != EW'(1)) : (edge_idx != EW'(2*DW)));
  assign last_sample = do_sample &&
                       (edge_idx == (cpha ? EW'(2*DW) : EW'(2*DW - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load)          tx_sh <= load_val;
      else if (do_shift) tx_sh <= {tx_sh[DW-2:0], 1'b0};
      if (do_sample) begin
        rx_sh <= {rx_sh[DW-2:0], ser_in};
        if (last_sample) begin
          word_q <= {rx_sh[DW-2:0], ser_in};
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ser_out = tx_sh[DW-1];
  assign done    = done_q;
  assign word    = word_q;

  p_done_gap_r1: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW          = 8,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             master_sel,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             fault_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_load,
  output logic [DW-1:0]    rx_data,
  output logic             rx_full,
  input  logic             rx_ack,
  output logic             mode_fault,
  input  logic             fault_clr,
  output logic             busy,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             ss_n_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             miso_i
);

  import spi_port_pkg::*;

  localparam int            EW        = $clog2(2*DW+1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2*DW - 1);

  // Synchronised slave-side pins: {sck, ss_n, mosi}
  logic [2:0] pins_s;
  logic       sck_s, ss_s, mosi_s;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_i, ss_n_i, mosi_i}),
    .q   (pins_s)
  );

  assign sck_s  = pins_s[2];
  assign ss_s   = pins_s[1];
  assign mosi_s = pins_s[0];

  logic          fault_q;
  role_e         role;
  logic          is_master, is_slave;

  always_comb begin
    if (!en || fault_q)  role = ROLE_OFF;
    else if (master_sel) role = ROLE_MASTER;
    else                 role = ROLE_SLAVE;
  end

  assign is_master = (role == ROLE_MASTER);
  assign is_slave  = (role == ROLE_SLAVE);

  // Master clock engine
  logic          m_start, m_abort, m_sck, m_stb, m_busy;
  logic [EW-1:0] m_idx;

  assign m_start = tx_load && is_master && !m_busy;
  assign m_abort = !is_master;

  spi_mclk #(.DW(DW), .DIV_W(DIV_W)) u_mclk (
    .clk      (clk),
    .rst      (rst),
    .start    (m_start),
    .abort    (m_abort),
    .cpol     (cpol),
    .div_sel  (div_sel),
    .sck      (m_sck),
    .edge_stb (m_stb),
    .edge_idx (m_idx),
    .busy     (m_busy)
  );

  // Slave edge tracking
  logic          sck_d, ss_d;
  logic [EW-1:0] s_edges_q;
  logic          s_edge, s_wrap, s_load;

  assign s_edge = is_slave && !ss_s && (sck_s != sck_d);
  assign s_wrap = s_edge && (s_edges_q == LAST_EDGE);
  assign s_load = is_slave && (ss_s || s_wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d     <= 1'b0;
      ss_d      <= 1'b1;
      s_edges_q <= '0;
    end else begin
      sck_d <= sck_s;
      ss_d  <= ss_s;
      if (!is_slave || ss_s) s_edges_q <= '0;
      else if (s_wrap)       s_edges_q <= '0;
      else if (s_edge)       s_edges_q <= s_edges_q + EW'(1);
    end
  end

  // Shared shifter
  logic [DW-1:0] tx_buf;
  logic          sh_load, sh_stb, sh_in, sh_out, sh_done;
  logic [DW-1:0] sh_val, sh_word;
  logic [EW-1:0] sh_idx;

  assign sh_load = m_start || s_load;
  assign sh_val  = m_start ? tx_data : tx_buf;
  assign sh_stb  = is_master ? m_stb : s_edge;
  assign sh_idx  = is_master ? m_idx : (s_edges_q + EW'(1));
  assign sh_in   = is_master ? miso_i : mosi_s;

  spi_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load),
    .load_val (sh_val),
    .edge_stb (sh_stb),
    .edge_idx (sh_idx),
    .cpha     (cpha),
    .ser_in   (sh_in),
    .ser_out  (sh_out),
    .done     (sh_done),
    .word     (sh_word)
  );

  // Fault detection, data registers and pin enables
  logic          fault_set;
  logic [DW-1:0] rx_q;
  logic          rx_full_q;
  logic          sck_oe_q, mosi_oe_q, miso_oe_q;

  assign fault_set = en && fault_en &&
                     ((master_sel && !ss_s) ||
                      (is_slave && ss_s && !ss_d && (s_edges_q != '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q   <= 1'b0;
      tx_buf    <= '0;
      rx_q      <= '0;
      rx_full_q <= 1'b0;
      sck_oe_q  <= 1'b0;
      mosi_oe_q <= 1'b0;
      miso_oe_q <= 1'b0;
    end else begin
      if (fault_set)      fault_q <= 1'b1;
      else if (fault_clr) fault_q <= 1'b0;
      if (tx_load) tx_buf <= tx_data;
      if (sh_done) begin
        rx_q      <= sh_word;
        rx_full_q <= 1'b1;
      end else if (rx_ack) begin
        rx_full_q <= 1'b0;
      end
      sck_oe_q  <= is_master;
      mosi_oe_q <= is_master;
      miso_oe_q <= is_slave && !ss_s;
    end
  end

  assign rx_data    = rx_q;
  assign rx_full    = rx_full_q;
  assign mode_fault = fault_q;
  assign busy       = m_busy;
  assign sck_o      = m_sck;
  assign sck_oe     = sck_oe_q;
  assign mosi_o     = sh_out;
  assign mosi_oe    = mosi_oe_q;
  assign miso_o     = sh_out;
  assign miso_oe    = miso_oe_q;

  p_rx_full_r1: assert property (@(posedge clk) disable iff (rst)
    sh_done |=> rx_full_q);

  p_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(sck_oe_q && miso_oe_q));

  p_en_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(sck_oe_q || mosi_oe_q || miso_oe_q));

  p_slave_hiz_r8: assert property (@(posedge clk) disable iff (rst)
    ss_s |=> !miso_oe_q);

  p_fault_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> !(sck_oe_q || mosi_oe_q || miso_oe_q));

  p_fault_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !fault_clr) |=> fault_q);

endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, master_sel = 1'b0, cpol = 1'b0, cpha = 1'b0, fault_en = 1'b0;
  logic [2:0] div_sel = '0;
  logic [7:0] tx_data = '0;
  logic       tx_load = 1'b0, rx_ack = 1'b0, fault_clr = 1'b0;
  logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, mode_fault, busy;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic prev_fault = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port u0 (
    .clk(clk), .rst(rst), .en(en), .master_sel(master_sel), .cpol(cpol), .cpha(cpha),
    .fault_en(fault_en), .div_sel(div_sel), .tx_data(tx_data), .tx_load(tx_load),
    .rx_data(rx_data), .rx_full(rx_full), .rx_ack(rx_ack), .mode_fault(mode_fault),
    .fault_clr(fault_clr), .busy(busy), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .ss_n_i(ss_n_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    rx_ack = 1'b1; tick(1); rx_ack = 1'b0; tick(1);
  endtask

  // Per-clock model: one cycle after the fault flag is seen, every driver is off;
  // the two clock directions never coexist.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_fault && mode_fault)
        chk("R9", "drivers while fault", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);
      chk("R5", "sck_oe with miso_oe", {31'd0, sck_oe & miso_oe}, 32'd0);
      prev_fault = mode_fault;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog R1: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Bench acts as slave peer to the master under test.
  task automatic master_xfer(input string req, input logic [7:0] mtx, input logic [7:0] ptx,
                             input logic pol, input logic pha, input logic [2:0] dv);
    logic [7:0] peer_sh, cap;
    int edges, gap, bad_gap;
    logic last;
    cpol = pol; cpha = pha; div_sel = dv;
    tick(3);
    chk("R3", "idle sck before", {31'd0, sck_o}, {31'd0, pol});
    peer_sh = ptx; miso_i = ptx[7]; cap = '0;
    tx_data = mtx; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    edges = 0; gap = 1; bad_gap = 0; last = sck_o;
    for (int g = 0; g < 4000 && edges < 16; g++) begin
      if (sck_o != last) begin
        edges++; last = sck_o;
        if (edges > 1 && gap != (1 << dv)) bad_gap++;
        gap = 0;
        if ((edges % 2 == 1) ^ pha) cap = {cap[6:0], mosi_o};
        else if (pha ? edges != 1 : edges != 16) begin
          peer_sh = {peer_sh[6:0], 1'b0}; miso_i = peer_sh[7];
        end
      end
      tick(1); gap++;
    end
    chk("R2", "edge count", edges, 16);
    chk("R2", "half-period mismatches", bad_gap, 0);
    tick(4 << dv);
    chk("R2", "no extra edge", {31'd0, sck_o}, {31'd0, pol});
    chk(req, "mosi byte", cap, mtx);
    chk(req, "rx_data", rx_data, ptx);
    chk(req, "rx_full", {31'd0, rx_full}, 32'd1);
    chk("R3", "idle sck after", {31'd0, sck_o}, {31'd0, pol});
    chk("R1", "busy after", {31'd0, busy}, 32'd0);
  endtask

  // Bench acts as master to the slave under test; ss is handled by the caller.
  task automatic slave_byte(input logic [7:0] mb, input logic ld_next,
                            input logic [7:0] nxt, output logic [7:0] got);
    logic [7:0] sh;
    sh = mb; mosi_i = mb[7]; got = '0;
    for (int e = 1; e <= 16; e++) begin
      if (ld_next && e == 4) begin
        tx_data = nxt; tx_load = 1'b1; tick(1); tx_load = 1'b0; tick(H - 1);
      end else tick(H);
      if ((e % 2 == 1) ^ cpha) got = {got[6:0], miso_o};
      sck_i = ~sck_i;
      if (!((e % 2 == 1) ^ cpha) && (cpha ? e != 1 : e != 16)) begin
        sh = {sh[6:0], 1'b0}; mosi_i = sh[7];
      end
    end
    tick(8);
  endtask

  logic [7:0] got;

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    chk("R5", "reset enables", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);
    chk("R13", "reset rx_full", {31'd0, rx_full}, 32'd0);
    chk("R11", "reset fault", {31'd0, mode_fault}, 32'd0);

    // Master role
    en = 1'b1; master_sel = 1'b1; tick(3);
    chk("R5", "master enables", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'b110);
    master_xfer("R1", 8'hA5, 8'h3C, 1'b0, 1'b0, 3'd0);
    pulse_ack();
    chk("R13", "ack clears", {31'd0, rx_full}, 32'd0);
    master_xfer("R1", 8'h01, 8'hFE, 1'b1, 1'b0, 3'd1);
    master_xfer("R4", 8'hC3, 8'h5A, 1'b0, 1'b1, 3'd2);
    master_xfer("R4", 8'h80, 8'h01, 1'b1, 1'b1, 3'd0);
    pulse_ack();

    // R10: select ignored with detection off
    fault_en = 1'b0; ss_n_i = 1'b0;
    master_xfer("R10", 8'h6E, 8'h91, 1'b0, 1'b0, 3'd1);
    chk("R10", "no fault", {31'd0, mode_fault}, 32'd0);
    ss_n_i = 1'b1; tick(3); pulse_ack();

    // R9: collision aborts a running master transfer
    fault_en = 1'b1; div_sel = 3'd2; tick(3);
    tx_data = 8'hF0; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    tick(10);
    ss_n_i = 1'b0; tick(6);
    chk("R9", "fault set", {31'd0, mode_fault}, 32'd1);
    chk("R9", "sck_oe off", {31'd0, sck_oe}, 32'd0);
    chk("R9", "mosi_oe off", {31'd0, mosi_oe}, 32'd0);
    chk("R9", "busy aborted", {31'd0, busy}, 32'd0);
    tick(80);
    chk("R9", "no rx_full", {31'd0, rx_full}, 32'd0);
    ss_n_i = 1'b1; tick(6);
    chk("R11", "sticky fault", {31'd0, mode_fault}, 32'd1);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0; tick(3);
    chk("R11", "cleared", {31'd0, mode_fault}, 32'd0);
    chk("R11", "master back", {31'd0, sck_oe}, 32'd1);
    master_xfer("R9", 8'h2D, 8'hD2, 1'b0, 1'b0, 3'd0);
    pulse_ack();

    // Slave role
    fault_en = 1'b0; master_sel = 1'b0; cpol = 1'b0; cpha = 1'b0; sck_i = 1'b0;
    tick(4);
    chk("R5", "slave enables ss high", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);
    tx_data = 8'h96; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    ss_n_i = 1'b0; tick(H);
    chk("R5", "slave miso_oe", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'b001);
    slave_byte(8'h5A, 1'b0, 8'h00, got);
    chk("R6", "miso byte", got, 8'h96);
    chk("R6", "rx_data", rx_data, 8'h5A);
    chk("R6", "rx_full", {31'd0, rx_full}, 32'd1);
    ss_n_i = 1'b1; tick(H); pulse_ack();

    // R7: phase 1, select held low, two bytes
    cpha = 1'b1; cpol = 1'b1; sck_i = 1'b1; tick(4);
    tx_data = 8'h11; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    ss_n_i = 1'b0; tick(H);
    slave_byte(8'hC3, 1'b1, 8'hE7, got);
    chk("R7", "first miso", got, 8'h11);
    chk("R7", "first rx", rx_data, 8'hC3);
    pulse_ack();
    slave_byte(8'h3C, 1'b0, 8'h00, got);
    chk("R7", "second miso", got, 8'hE7);
    chk("R7", "second rx", rx_data, 8'h3C);
    chk("R7", "second rx_full", {31'd0, rx_full}, 32'd1);
    ss_n_i = 1'b1; tick(H); pulse_ack();

    // R8: clocks with select high are ignored
    cpha = 1'b0; cpol = 1'b0; sck_i = 1'b0; tick(4);
    tx_data = 8'h42; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    for (int k = 0; k < 6; k++) begin
      mosi_i = k[0]; sck_i = ~sck_i; tick(H);
      chk("R8", "miso_oe while deselected", {31'd0, miso_oe}, 32'd0);
    end
    chk("R8", "no rx_full", {31'd0, rx_full}, 32'd0);
    // cut a byte short, detection off: no fault, byte discarded
    ss_n_i = 1'b0; tick(H);
    for (int k = 0; k < 5; k++) begin sck_i = ~sck_i; tick(H); end
    ss_n_i = 1'b1; tick(H);
    chk("R12", "no fault when disabled", {31'd0, mode_fault}, 32'd0);
    sck_i = 1'b0; tick(H);
    ss_n_i = 1'b0; tick(H);
    slave_byte(8'h81, 1'b0, 8'h00, got);
    chk("R8", "miso after abort", got, 8'h42);
    chk("R8", "rx after abort", rx_data, 8'h81);
    ss_n_i = 1'b1; tick(H); pulse_ack();

    // R12: slave fault on early select rise
    fault_en = 1'b1; tick(2);
    ss_n_i = 1'b0; tick(H);
    for (int k = 0; k < 3; k++) begin sck_i = ~sck_i; tick(H); end
    ss_n_i = 1'b1; tick(6);
    chk("R12", "slave fault", {31'd0, mode_fault}, 32'd1);
    chk("R12", "miso off", {31'd0, miso_oe}, 32'd0);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0; tick(3);
    chk("R11", "slave fault cleared", {31'd0, mode_fault}, 32'd0);

    // R5: disable
    en = 1'b0; tick(3);
    chk("R5", "disabled enables", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule